// File: doc/BRIEF.md
# Dual-Convention Multiplexed Bus Slave

This block lets an external host reach a 128-entry byte register file over an 8-bit bus that carries both address and data on the same pins. Each access opens with a positive pulse on an address strobe. The block captures the address when that pulse ends. Later in the same access, data moves on the same pins, in one direction or the other. A strap input picks one of two incompatible strobe conventions. The first is a single active-high data strobe paired with a direction level. The second uses two separate active-low strobes, one for reads and one for writes. An active-low chip select gates every access.

All host pins are asynchronous to the system clock. The block samples them through a chain of flip-flops and detects edges on the synchronized copies. The bus word is delayed by one stage more than the strobes. This extra stage means an edge always pairs with the bus value from the last clock before that edge. The register file sits outside the block and has two ports. The read port is a combinational lookup at the latched address. The write port is a one-cycle valid pulse carrying address and data. This port has no ready signal, because a host bus cycle cannot be stalled, so the file must accept every pulse. While the block drives the bus, it presents the data together with an output-enable. When that enable is low, the pins are meant to float.

Top module: `muxbus_slave`

## Requirements
- R1: When the synchronized address strobe falls, the block latches `bus_in[6:0]` as sampled on the last clock the strobe was still high. `bus_in[7]` plays no part in the address. `rf_rd_addr` changes at no other time.
- R2: `mode_strap` is sampled only while `rst_n` is low. A value of 1 selects the data-strobe convention and 0 selects the split-strobe convention. A change on the strap after reset has no effect until the next reset.
- R3: In the data-strobe convention, `strb_a` is the data strobe (active high) and `strb_b` is the direction level (1 = read). A read with `cs_n` low drives `rf_rd_data` for the latched address onto `bus_out` with `bus_oe` high. The drive ends after `strb_a` falls.
- R4: In the split-strobe convention, `strb_a` is the active-low read strobe. A read with `cs_n` low drives the addressed byte with `bus_oe` high, and the drive ends after `strb_a` returns high.
- R5: In the data-strobe convention, a falling `strb_a` while `strb_b` is 0 and `cs_n` is low produces one `rf_wr_valid` pulse. The pulse carries the latched address and the bus value from the last clock before the fall.
- R6: In the split-strobe convention, `strb_b` is the active-low write strobe. Its rising edge with `cs_n` low produces one `rf_wr_valid` pulse carrying the latched address and the bus value from the last clock before the rise.
- R7: With `cs_n` high, no read drive (`bus_oe` stays 0) and no write pulse takes place.
- R8: With the default two synchronizer stages, `bus_oe` rises after the third rising clock edge following the start of a read strobe. It falls after the third rising edge following the end of that strobe.
- R9: During and right after reset, `bus_oe` and `rf_wr_valid` are 0 and `rf_rd_addr` is 0.
- R10: A read cycle never produces a write pulse, and `bus_oe` and `rf_wr_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the host strobes |
| rst_n | input | 1 | Synchronous active-low reset; strap is captured while low |
| mode_strap | input | 1 | Convention select: 1 data-strobe, 0 split strobes |
| cs_n | input | 1 | Active-low chip select |
| addr_stb | input | 1 | Active-high address strobe; address captured on its fall |
| strb_a | input | 1 | Data strobe (data-strobe mode) or read strobe, active low (split mode) |
| strb_b | input | 1 | Direction level, 1 = read (data-strobe mode) or write strobe, active low (split mode) |
| bus_in | input | 8 | Bus pins as seen by the block |
| bus_out | output | 8 | Read data to drive onto the bus |
| bus_oe | output | 1 | Bus drive enable; bus floats when low |
| rf_rd_addr | output | 7 | Register file read address (latched address) |
| rf_rd_data | input | 8 | Register file read data for `rf_rd_addr` |
| rf_wr_valid | output | 1 | One-cycle write pulse, no back-pressure |
| rf_wr_addr | output | 7 | Write address, valid with `rf_wr_valid` |
| rf_wr_data | output | 8 | Write data, valid with `rf_wr_valid` |

## Verification
Two checks are hard to reach from the ports. The first is the pairing of a trailing strobe edge with the bus value from the clock before it. The bench changes the bus to a different value in the same cycle that it ends the write strobe. A design that took the value one clock late would then record the wrong byte. The second is the strap being ignored after reset. To test it, the bench resets in data-strobe mode, flips the strap, and runs a data-strobe write. That write must still commit. Drive-enable latency is measured edge by edge around one split-mode read.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  localparam int MB_ADDR_W      = 7;
  localparam int MB_DATA_W      = 8;
  localparam int MB_SYNC_STAGES = 2;

  typedef enum logic {
    CONV_SPLIT   = 1'b0,
    CONV_DSTROBE = 1'b1
  } conv_e;

  typedef struct packed {
    logic cs_n;
    logic as_lvl;
    logic sa;
    logic sb;
  } ctrl_t;
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= RST;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= RST;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbs_cycle_decode.sv
module mbs_cycle_decode
  import muxbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  conv_e conv,
  input  ctrl_t ctrl_s,
  output logic  addr_capture,
  output logic  read_active,
  output logic  write_commit
);
  ctrl_t ctrl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_d <= '{cs_n: 1'b1, as_lvl: 1'b0, sa: 1'b0, sb: 1'b0};
    else        ctrl_d <= ctrl_s;
  end

  logic ds_read, ds_write, sp_read, sp_write;

  // data-strobe convention: sa = strobe (high active), sb = direction (1 read)
  assign ds_read  = !ctrl_s.cs_n && ctrl_s.sa && ctrl_s.sb;
  assign ds_write = !ctrl_d.cs_n && ctrl_d.sa && !ctrl_s.sa && !ctrl_d.sb;
  // split convention: sa = read strobe low, sb = write strobe low
  assign sp_read  = !ctrl_s.cs_n && !ctrl_s.sa;
  assign sp_write = !ctrl_d.cs_n && !ctrl_d.sb && ctrl_s.sb;

  assign addr_capture = ctrl_d.as_lvl && !ctrl_s.as_lvl;
  assign read_active  = (conv == CONV_DSTROBE) ? ds_read  : sp_read;
  assign write_commit = (conv == CONV_DSTROBE) ? ds_write : sp_write;
endmodule

// File: rtl/mbs_read_drive.sv
module mbs_read_drive #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              read_active,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      bus_oe <= read_active;
      if (read_active) bus_out <= rd_data;
    end
  end
endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
  import muxbus_pkg::*;
#(
  parameter int ADDR_W      = MB_ADDR_W,
  parameter int DATA_W      = MB_DATA_W,
  parameter int SYNC_STAGES = MB_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_strap,
  input  logic              cs_n,
  input  logic              addr_stb,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] rf_rd_addr,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_wr_valid,
  output logic [ADDR_W-1:0] rf_wr_addr,
  output logic [DATA_W-1:0] rf_wr_data
);
  localparam int         CTRL_W     = $bits(ctrl_t);
  localparam int         BUS_STAGES = SYNC_STAGES + 1;
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b1000;

  conv_e             conv_q;
  ctrl_t             ctrl_s;
  logic [CTRL_W-1:0] ctrl_raw, ctrl_sv;
  logic [DATA_W-1:0] bus_d;
  logic              addr_capture, read_active, write_commit;
  logic [ADDR_W-1:0] addr_q;

  // strap captured on every clock while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) conv_q <= conv_e'(mode_strap);
  end

  assign ctrl_raw = {cs_n, addr_stb, strb_a, strb_b};

  mbs_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST(CTRL_IDLE)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_sv)
  );
  assign ctrl_s = ctrl_t'(ctrl_sv);

  // one stage deeper: aligned with the previous strobe sample
  mbs_sync #(.W(DATA_W), .STAGES(BUS_STAGES), .RST('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_d)
  );

  mbs_cycle_decode u_decode (
    .clk(clk), .rst_n(rst_n), .conv(conv_q), .ctrl_s(ctrl_s),
    .addr_capture(addr_capture), .read_active(read_active),
    .write_commit(write_commit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            addr_q <= '0;
    else if (addr_capture) addr_q <= bus_d[ADDR_W-1:0];
  end
  assign rf_rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_wr_valid <= 1'b0;
      rf_wr_addr  <= '0;
      rf_wr_data  <= '0;
    end else begin
      rf_wr_valid <= write_commit;
      if (write_commit) begin
        rf_wr_addr <= addr_q;
        rf_wr_data <= bus_d;
      end
    end
  end

  mbs_read_drive #(.DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .read_active(read_active),
    .rd_data(rf_rd_data), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_capture |=> $stable(rf_rd_addr));

  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid |=> !rf_wr_valid);

  assert_drive_needs_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(!ctrl_s.cs_n));

  assert_drive_write_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !rf_wr_valid);
endmodule

// File: tb/muxbus_slave_bench.sv
module muxbus_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_strap = 1'b1;
  logic       cs_n = 1'b1, addr_stb = 1'b0, strb_a = 1'b0, strb_b = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out, rf_rd_data, rf_wr_data;
  logic       bus_oe, rf_wr_valid;
  logic [6:0] rf_rd_addr, rf_wr_addr;

  int checks = 0, errors = 0;
  int wr_pulses = 0;
  logic [6:0] last_wr_addr;
  logic [7:0] last_wr_data;
  logic [7:0] rf_mem [128];

  always #2 clk = ~clk;

  muxbus_slave u_muxbus_slave (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .cs_n(cs_n),
    .addr_stb(addr_stb), .strb_a(strb_a), .strb_b(strb_b), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .rf_rd_addr(rf_rd_addr),
    .rf_rd_data(rf_rd_data), .rf_wr_valid(rf_wr_valid),
    .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data)
  );

  assign rf_rd_data = rf_mem[rf_rd_addr];

  initial for (int i = 0; i < 128; i++) rf_mem[i] = 8'h00;

  always @(posedge clk) if (rst_n && rf_wr_valid) begin
    rf_mem[rf_wr_addr] <= rf_wr_data;
    wr_pulses    <= wr_pulses + 1;
    last_wr_addr <= rf_wr_addr;
    last_wr_data <= rf_wr_data;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_strobes(input logic ds);
    cs_n = 1'b1; addr_stb = 1'b0; strb_b = 1'b1;
    strb_a = ds ? 1'b0 : 1'b1;
  endtask

  task automatic do_reset(input logic ds);
    @(negedge clk);
    rst_n = 1'b0; mode_strap = ds; idle_strobes(ds);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic addr_phase(input logic cs, input logic [6:0] a);
    @(negedge clk);
    cs_n = !cs; bus_in = {1'b1, a}; addr_stb = 1'b1;
    repeat (2) @(negedge clk);
    addr_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_cycle(input logic ds, input logic wr, input logic cs,
                           input logic [6:0] a, input logic [7:0] d,
                           output logic oe_seen, output logic [7:0] rdv,
                           output int wrs);
    int start;
    start = wr_pulses; oe_seen = 1'b0; rdv = 8'h00;
    addr_phase(cs, a);
    bus_in = wr ? d : 8'h00;
    if (ds) begin strb_b = !wr; strb_a = 1'b1; end
    else if (wr) strb_b = 1'b0;
    else         strb_a = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (bus_oe) begin oe_seen = 1'b1; rdv = bus_out; end
    end
    // end strobe and disturb the bus in the same cycle
    if (ds) strb_a = 1'b0;
    else begin strb_a = 1'b1; strb_b = 1'b1; end
    bus_in = ~d;
    repeat (5) @(negedge clk);
    idle_strobes(ds);
    @(negedge clk);
    wrs = wr_pulses - start;
  endtask

  // {conv(1=data strobe), wr, cs, addr[6:0], data[7:0]}
  localparam logic [17:0] VEC [12] = '{
    {1'b1, 1'b1, 1'b1, 7'h05, 8'hA5},
    {1'b1, 1'b0, 1'b1, 7'h05, 8'hA5},
    {1'b1, 1'b1, 1'b1, 7'h7F, 8'h3C},
    {1'b1, 1'b1, 1'b0, 7'h05, 8'hFF},
    {1'b1, 1'b0, 1'b1, 7'h05, 8'hA5},
    {1'b1, 1'b0, 1'b1, 7'h7F, 8'h3C},
    {1'b1, 1'b0, 1'b0, 7'h7F, 8'h3C},
    {1'b0, 1'b1, 1'b1, 7'h00, 8'h81},
    {1'b0, 1'b0, 1'b1, 7'h00, 8'h81},
    {1'b0, 1'b1, 1'b1, 7'h05, 8'h5A},
    {1'b0, 1'b0, 1'b1, 7'h05, 8'h5A},
    {1'b0, 1'b0, 1'b0, 7'h00, 8'h81}
  };

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic oe_seen;
    logic [7:0] rdv;
    int wrs;
    logic cur_ds;

    // R9: reset state
    repeat (3) @(negedge clk);
    check(bus_oe == 1'b0, "R9 oe in reset", bus_oe, 0);
    check(rf_wr_valid == 1'b0, "R9 wr_valid in reset", rf_wr_valid, 0);
    check(rf_rd_addr == 7'h00, "R9 rd_addr in reset", rf_rd_addr, 0);
    do_reset(1'b1);
    cur_ds = 1'b1;
    check(bus_oe == 1'b0, "R9 oe after reset", bus_oe, 0);

    for (int i = 0; i < 12; i++) begin
      logic ds, wr, cs;
      logic [6:0] a;
      logic [7:0] d;
      {ds, wr, cs, a, d} = VEC[i];
      if (ds != cur_ds) begin do_reset(ds); cur_ds = ds; end
      bus_cycle(ds, wr, cs, a, d, oe_seen, rdv, wrs);
      if (wr) begin
        // R5 (data strobe) / R6 (split) / R7 (deselected)
        check(wrs == (cs ? 1 : 0), ds ? "R5 R7 write pulse count" : "R6 R7 write pulse count", wrs, cs ? 1 : 0);
        if (cs) begin
          check(last_wr_addr == a, "R1 write address", last_wr_addr, a);
          check(last_wr_data == d, ds ? "R5 write data" : "R6 write data", last_wr_data, d);
        end
      end else begin
        check(wrs == 0, "R10 read makes no write", wrs, 0);
        check(oe_seen == cs, ds ? "R3 R7 drive seen" : "R4 R7 drive seen", oe_seen, cs);
        if (cs) check(rdv == d, ds ? "R3 read data" : "R4 read data", rdv, d);
      end
      check(bus_oe == 1'b0, ds ? "R3 drive released" : "R4 drive released", bus_oe, 0);
    end

    // R8: drive-enable latency, split mode
    addr_phase(1'b1, 7'h05);
    strb_a = 1'b0;
    @(negedge clk); @(negedge clk);
    check(bus_oe == 1'b0, "R8 oe before third edge", bus_oe, 0);
    @(negedge clk);
    check(bus_oe == 1'b1, "R8 oe after third edge", bus_oe, 1);
    check(bus_out == 8'h5A, "R4 data at latency point", bus_out, 8'h5A);
    strb_a = 1'b1;
    @(negedge clk); @(negedge clk);
    check(bus_oe == 1'b1, "R8 oe held two edges", bus_oe, 1);
    @(negedge clk);
    check(bus_oe == 1'b0, "R8 oe off after third edge", bus_oe, 0);
    idle_strobes(1'b0);
    repeat (2) @(negedge clk);

    // R2: strap change after reset is ignored
    do_reset(1'b1);
    mode_strap = 1'b0;
    bus_cycle(1'b1, 1'b1, 1'b1, 7'h33, 8'hC7, oe_seen, rdv, wrs);
    check(wrs == 1, "R2 data-strobe write after strap flip", wrs, 1);
    check(last_wr_data == 8'hC7, "R2 write data after strap flip", last_wr_data, 8'hC7);
    bus_cycle(1'b1, 1'b0, 1'b1, 7'h33, 8'h00, oe_seen, rdv, wrs);
    check(oe_seen && rdv == 8'hC7, "R2 data-strobe read after strap flip", rdv, 8'hC7);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule